// File: doc/BRIEF.md
# Interrupt Trigger Controller

This block takes a group of external interrupt request lines and folds them into a single service request for a processor. Each line has its own trigger setting. In level mode the line asks for service for as long as it stays at its active level. In edge mode one transition in the chosen direction sets a pending flag, and that flag stays set until software clears it. A per-line polarity bit picks high or low for level mode, and rising or falling for edge mode.

Raw lines first go through a two-flop synchronizer. After that they are looked at only on cycles where a sample-enable pulse is high; that pulse stands for the processor's instruction cycle. Software reaches four registers over a small bus: status, mask, mode and polarity. The block drives two outputs. One is the combined request. The other is the index of the lowest-numbered line that is requesting and not masked.

Several devices can share one level-mode line as a wired-OR. Software then finds the device by polling, because the status register shows the sampled level of every level-mode line.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: For a line in level mode (mode bit 0), the line requests service while its most recent sample is at the active level, and the request drops once a sample finds the line inactive.
- R2: Polarity bit 1 makes a line active high, or rising-edge in edge mode. Polarity bit 0 makes it active low, or falling-edge in edge mode. Each line has its own polarity bit.
- R3: For a line in edge mode (mode bit 1), a sampled inactive-to-active transition sets its pending bit. If the line is held at the active level after that, the bit is not set again, even after it has been cleared.
- R4: Once an edge-mode line has triggered, a new pending event is recorded only after the line is sampled inactive and then sampled active again.
- R5: A pending bit stays set until software writes 1 to that bit of the status register (address 0). When a new edge and that clear land in the same cycle, the bit ends up set.
- R6: Lines are taken in only on cycles with sample_en high. A line change that happens while sample_en is low has no effect until the next sample.
- R7: Reading status returns the pending bit for an edge-mode line and the sampled active level for a level-mode line. Writing status has no effect on level-mode lines.
- R8: When a line's mask bit (address 1) is set to 1, that line cannot drive irq_req, and its pending bit is kept. Clearing the mask bit brings the request back if the bit is still pending.
- R9: irq_req is high exactly when at least one unmasked line is requesting. irq_idx gives the lowest-numbered such line, and is 0 when none is.
- R10: After reset every line is in level mode (address 2 reads 0), active high (address 3 reads all ones) and masked (address 1 reads all ones). No bit is pending, and irq_req and irq_idx are 0.
- R11: The mask, mode and polarity registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | N_LINES | Asynchronous interrupt request lines |
| sample_en | input | 1 | Sample strobe, one pulse per instruction cycle |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 mask, 2 mode, 3 polarity |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data for the register selected by bus_addr, combinational |
| irq_req | output | 1 | Combined request to the processor |
| irq_idx | output | IDX_W | Lowest unmasked requesting line |

## Verification
The assertions rely on the polarity and mode registers staying still while a line is part-way through a transition. If either one is rewritten at that point, the line can appear to produce an edge the device never made. The stimulus therefore sets up polarity and mode while each line sits at its inactive level, and only then moves the lines. The lines are driven on falling clock edges, away from the sampling edge. They are given enough cycles to cross the synchronizer and reach a sample before any result is compared.

// File: rtl/irq_trig_pkg.sv
// Shared definitions for the interrupt trigger controller.
// Assumes: the register bus uses a 2-bit word address.
package irq_trig_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_MODE   = 2'd2,
        REG_POL    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous lines.
// Assumes: each bit is treated alone, so no coherence between bits is implied.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Move the raw lines through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/irq_line_cond.sv
// Conditions one synchronized request line: applies polarity, samples on
// the strobe, finds the active transition and keeps the pending latch.
// Assumes: line_sync is already synchronous to clk.
module irq_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic line_sync,
    input  logic pol_high,
    input  logic edge_mode,
    input  logic clr,
    output logic lvl_q,
    output logic pend_q,
    output logic req,
    output logic stat
);
    logic act_now;
    logic hit;

    // Normalize the line so that 1 always means active.
    always_comb act_now = pol_high ? line_sync : ~line_sync;

    // An edge counts only when a sample moves the line from inactive to active.
    always_comb hit = sample_en & edge_mode & act_now & ~lvl_q;

    // Keep the last sampled active state.
    always_ff @(posedge clk) begin
        if (!rst_n)         lvl_q <= 1'b0;
        else if (sample_en) lvl_q <= act_now;
    end

    // Pending latch: a new edge takes priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (hit) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    // The mode picks which state requests service and is shown to software.
    always_comb begin
        req  = edge_mode ? pend_q : lvl_q;
        stat = req;
    end
endmodule

// File: rtl/irq_regs.sv
// Software-visible registers: mask, mode, polarity, the read mux and the
// write-1-to-clear strobe for the status register.
// Assumes: one write per cycle, read data is combinational from bus_addr.
module irq_regs
    import irq_trig_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic [N-1:0]      stat_vec,
    output logic [N-1:0]      bus_rdata,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      mode_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      clr_vec
);
    reg_sel_e sel;

    always_comb sel = reg_sel_e'(bus_addr);

    // Store the configuration registers; reset leaves lines masked, level, high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= '0;
            pol_q  <= '1;
        end else if (bus_wen) begin
            case (sel)
                REG_MASK: mask_q <= bus_wdata;
                REG_MODE: mode_q <= bus_wdata;
                REG_POL:  pol_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // A status write produces the per-line clear strobes.
    always_comb clr_vec = (bus_wen && sel == REG_STATUS) ? bus_wdata : '0;

    // Choose the register that the bus reads.
    always_comb begin
        case (sel)
            REG_STATUS: bus_rdata = stat_vec;
            REG_MASK:   bus_rdata = mask_q;
            REG_MODE:   bus_rdata = mode_q;
            default:    bus_rdata = pol_q;
        endcase
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Lowest-index priority encoder over the unmasked request vector.
// Assumes: N >= 2; the index is 0 when no bit is set.
module irq_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_trigger_ctrl.sv
// Top level of the configurable interrupt trigger controller. Each line is
// synchronized, conditioned by its own mode and polarity, masked and
// combined into one request plus a lowest-index number.
// Assumes: N_LINES >= 2 and at most 32, sample_en is synchronous to clk.
module irq_trigger_ctrl
    import irq_trig_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               sample_en,
    input  logic               bus_wen,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx
);
    logic [N_LINES-1:0] sync_vec;
    logic [N_LINES-1:0] lvl_vec;
    logic [N_LINES-1:0] pend_vec;
    logic [N_LINES-1:0] req_vec;
    logic [N_LINES-1:0] stat_vec;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] pol_q;
    logic [N_LINES-1:0] clr_vec;
    logic [N_LINES-1:0] vis_vec;

    irq_sync #(.W(N_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_lines),
        .q_sync  (sync_vec)
    );

    irq_regs #(.N(N_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_vec  (stat_vec),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_q),
        .mode_q    (mode_q),
        .pol_q     (pol_q),
        .clr_vec   (clr_vec)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .line_sync (sync_vec[g]),
            .pol_high  (pol_q[g]),
            .edge_mode (mode_q[g]),
            .clr       (clr_vec[g]),
            .lvl_q     (lvl_vec[g]),
            .pend_q    (pend_vec[g]),
            .req       (req_vec[g]),
            .stat      (stat_vec[g])
        );
    end

    // Masked lines drop out before lines are combined.
    always_comb vis_vec = req_vec & ~mask_q;

    irq_prio_enc #(.N(N_LINES), .IDX_W(IDX_W)) u_enc (
        .vec (vis_vec),
        .any (irq_req),
        .idx (irq_idx)
    );
endmodule

// File: rtl/irq_trig_chk.sv
// Checker for the trigger controller: pending hold, edge origin, sample
// gating and request/index consistency.
// Assumes: bound into irq_trigger_ctrl, with the internal state vectors connected.
module irq_trig_chk
    import irq_trig_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic              irq_req,
    input logic [IDX_W-1:0]  irq_idx,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      lvl,
    input logic [N-1:0]      mode,
    input logic [N-1:0]      mask
);
    logic [N-1:0] clr_c;
    logic [N-1:0] vis_c;
    logic [N-1:0] below_c;

    always_comb begin
        clr_c   = (bus_wen && bus_addr == ADDR_W'(0)) ? bus_wdata : '0;
        vis_c   = ((mode & pend) | (~mode & lvl)) & ~mask;
        below_c = (N'(1) << irq_idx) - N'(1);
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr_c) & ~pend) == '0));

    // R3
    pend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~(lvl & ~$past(lvl))) == '0));

    // R6
    sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(lvl));

    // R9
    req_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (vis_c != '0));

    // R9
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vis_c[irq_idx] && ((vis_c & below_c) == '0)));

    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_req);
endmodule

bind irq_trigger_ctrl irq_trig_chk #(.N(N_LINES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .irq_idx   (irq_idx),
    .pend      (pend_vec),
    .lvl       (lvl_vec),
    .mode      (mode_q),
    .mask      (mask_q)
);

// File: tb/test_irq_trigger_ctrl.sv
module test_irq_trigger_ctrl;
    localparam int N     = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     irq_lines = '0;
    logic             sample_en = 1'b1;
    logic             bus_wen = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [N-1:0]     bus_wdata = '0;
    logic [N-1:0]     bus_rdata;
    logic             irq_req;
    logic [IDX_W-1:0] irq_idx;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [1:0]       addr;
        logic             req;
        logic [IDX_W-1:0] idx;
        logic [N-1:0]     rdata;
        string            tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_trigger_ctrl #(.N_LINES(N)) i_irq_trigger_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .sample_en (sample_en),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx)
    );

    // Monitor: compare the oldest expected item at a falling edge.
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            @(negedge clk);
            checks++;
            if (irq_req !== sb_q[0].req || irq_idx !== sb_q[0].idx ||
                bus_rdata !== sb_q[0].rdata) begin
                errors++;
                $display("FAIL %s: req=%0b idx=%0d rdata=%h expected req=%0b idx=%0d rdata=%h",
                         sb_q[0].tag, irq_req, irq_idx, bus_rdata,
                         sb_q[0].req, sb_q[0].idx, sb_q[0].rdata);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    // Driver: push one expected item and wait until the monitor has used it.
    task automatic expect_state(input logic [1:0] a, input logic r,
                                input logic [IDX_W-1:0] i,
                                input logic [N-1:0] d, input string t);
        exp_t e;
        bus_addr = a;
        e.addr = a; e.req = r; e.idx = i; e.rdata = d; e.tag = t;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state and defaults
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R10 status");
        expect_state(2'd1, 1'b0, 3'd0, 8'hFF, "R10 mask");
        expect_state(2'd2, 1'b0, 3'd0, 8'h00, "R10 mode");
        expect_state(2'd3, 1'b0, 3'd0, 8'hFF, "R10 pol");

        bus_write(2'd1, 8'h00);
        // R11 readback
        expect_state(2'd1, 1'b0, 3'd0, 8'h00, "R11 mask");

        // R1 level mode, active high
        irq_lines[2] = 1'b1; settle();
        expect_state(2'd0, 1'b1, 3'd2, 8'h04, "R1 level held");
        irq_lines[2] = 1'b0; settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R1 level dropped");

        // R7 wired-OR polling shows raw levels; status write ignored
        irq_lines[5] = 1'b1; irq_lines[3] = 1'b1; settle();
        expect_state(2'd0, 1'b1, 3'd3, 8'h28, "R7 level status");
        bus_write(2'd0, 8'hFF); settle();
        expect_state(2'd0, 1'b1, 3'd3, 8'h28, "R7 clear ignored");
        irq_lines[5] = 1'b0; irq_lines[3] = 1'b0; settle();

        // R2 active-low level on line 1
        bus_write(2'd3, 8'hFD); settle();
        expect_state(2'd0, 1'b1, 3'd1, 8'h02, "R2 low active");
        irq_lines[1] = 1'b1; settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R2 high inactive");

        // R2/R3 falling-edge mode on line 1, R11 mode readback
        bus_write(2'd2, 8'h12);
        expect_state(2'd2, 1'b0, 3'd0, 8'h12, "R11 mode");
        irq_lines[1] = 1'b0; settle();
        expect_state(2'd0, 1'b1, 3'd1, 8'h02, "R2 falling edge pending");
        settle();
        expect_state(2'd0, 1'b1, 3'd1, 8'h02, "R5 pending held");
        bus_write(2'd0, 8'h02); settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R3 no retrigger while low");
        irq_lines[1] = 1'b1; settle();
        irq_lines[1] = 1'b0; settle();
        expect_state(2'd0, 1'b1, 3'd1, 8'h02, "R4 new edge after release");
        bus_write(2'd0, 8'h02);

        // R3 rising edge on line 4 held high
        irq_lines[4] = 1'b1; settle();
        expect_state(2'd0, 1'b1, 3'd4, 8'h10, "R3 rising edge pending");
        bus_write(2'd0, 8'h10); settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R3 held high no retrigger");
        irq_lines[4] = 1'b0; settle();

        // R5 set wins over a clear in the same cycle
        @(negedge clk);
        irq_lines[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h10;
        @(negedge clk);
        bus_wen = 1'b0;
        settle();
        expect_state(2'd0, 1'b1, 3'd4, 8'h10, "R5 set beats clear");

        // R8 mask keeps pending
        bus_write(2'd1, 8'h10); settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h10, "R8 masked pending kept");
        bus_write(2'd1, 8'h00); settle();
        expect_state(2'd0, 1'b1, 3'd4, 8'h10, "R8 unmask restores");

        // R9 lowest unmasked index
        irq_lines[2] = 1'b1; irq_lines[6] = 1'b1; settle();
        expect_state(2'd0, 1'b1, 3'd2, 8'h54, "R9 lowest of three");
        bus_write(2'd1, 8'h04); settle();
        expect_state(2'd0, 1'b1, 3'd4, 8'h54, "R9 lowest masked skipped");
        bus_write(2'd1, 8'hFF); settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h54, "R9 all masked");
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h10);
        irq_lines[2] = 1'b0; irq_lines[6] = 1'b0; settle();
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R9 none requesting");

        // R6 sample gating
        sample_en = 1'b0;
        irq_lines[0] = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        expect_state(2'd0, 1'b0, 3'd0, 8'h00, "R6 no sample no change");
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        expect_state(2'd0, 1'b1, 3'd0, 8'h01, "R6 recognized at sample");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule